// File: doc/BRIEF.md
# LUT configuration string generator

This block turns a 64-bit truth-table initialisation value into the 64-bit pattern that has to be written into configuration memory for one look-up table. Each of the six LUT inputs A1..A6 has a fixed 64-bit basis string, supplied as a parameter. For every truth-table row that is enabled, the block forms a minterm. The minterm is the bitwise AND of each input's basis string, or of its complement where that row has the input at 0. The block then ORs all the minterms into an accumulator. It handles one row per clock cycle.

The kind input selects one of three modes: 6-input logic, 5-input logic, or a shift-register primitive. The slice flag selects the logic-only layout or the memory-capable layout of the result. A conversion starts on a rising edge of the start pin. The ready pin then goes high and stays high while the result is valid. A reconfiguration controller waits for ready and then copies the result into the configuration bitstream. Control pins are plain levels, and the block applies no back-pressure. A start edge that arrives while a conversion is running is dropped. The result stays valid until the next start edge or a soft clear.

Top module: `lut_cfg_gen`

## Requirements
- R1: A conversion starts only on a rising edge of `start`, sampled at a clock edge where `start` is high and was low at the previous clock edge (the level before the first edge after reset counts as low). Holding `start` high does not start a second conversion.
- R2: If the rising edge of `start` is sampled at clock edge T, `cfg_ready` is low after edge T and goes high after edge T+64. Rows 0..63 are processed one per edge from T+1 to T+64.
- R3: While `cfg_ready` is low, `cfg_string` is zero. While it is high, `cfg_string` keeps its value until a new conversion starts or a soft clear occurs.
- R4: Kind 2'b00 is 6-input logic, and kind 2'b11 behaves the same way. In row r, input Ak takes bit k-1 of r. The result is the OR, over every r with `init_value[r]`=1, of the AND over k=1..6 of Bk when that input is 1 and ~Bk when it is 0. The default basis strings are B1=0x5555555555555555, B2=0x3333333333333333, B3=0x0000FFFF0000FFFF, B4=0x0F0F0F0F0F0F0F0F, B5=0x00FF00FF00FF00FF and B6=0xFFFFFFFF00000000. With these defaults, 6-input logic with init 0x1 on a logic-only slice gives 0x0000000080000000.
- R5: Kind 2'b01 is 5-input logic. Only rows 0..31 (`init_value[31:0]`) can contribute, and A6 is left out of the minterm AND. `init_value[63:32]` has no effect on the result.
- R6: Kind 2'b10 is the shift-register primitive. Row r is enabled when `init_value[r/2]` is 1. This means the odd row, where A1=1 and which feeds the read multiplexer, and the even row below it, which feeds the shift output, are both enabled by that bit. A2..A6 form the tap address. `init_value[63:32]` has no effect. With the default basis strings, init 0x5 on a memory-capable slice gives 0xC000C00000000000.
- R7: When `mem_slice`=1, the result is split into 16-bit chunks c0 (bits 63:48), c1, c2 and c3. These are output in the order c2,c3,c1,c0 from the most significant end. When `mem_slice`=0, the result is output unchanged.
- R8: A start edge that arrives while a conversion is running is ignored. The running conversion finishes on schedule, using the init value, kind and slice flag that were captured when it started.
- R9: `soft_clr` is synchronous. After the edge that samples it high, `cfg_ready` is low, `cfg_string` is zero, and any running conversion is abandoned. A start edge sampled at the same edge is dropped.
- R10: An asynchronous active-low reset `rst_n` drives `cfg_ready` low and `cfg_string` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of the result and any running conversion |
| start | input | 1 | A rising edge starts a conversion |
| init_value | input | 64 | Truth-table initialisation value |
| lut_kind | input | 2 | 00 6-input, 01 5-input, 10 shift register, 11 as 00 |
| mem_slice | input | 1 | 1 selects the memory-capable chunk order |
| cfg_string | output | 64 | Configuration pattern, zero while not ready |
| cfg_ready | output | 1 | High while `cfg_string` holds a finished result |

## Verification
Two pairs of events can fall in the same clock edge. A start edge can coincide with a soft clear, and a start edge can coincide with the final row of a running conversion. The bench raises `start` and `soft_clr` at the same falling edge, and it also pulses `start` in the middle of a scan and again exactly on the last row. A behavioural model decides which event wins, and the bench compares `cfg_ready` and `cfg_string` with that model at every cycle. In the model, the clear always wins, and the busy scan swallows any start edge, including one on its final row. Known constant results for the 6-input case and the shift-register case check the model against fixed numbers.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  localparam int N_IN    = 6;
  localparam int ROWS    = 1 << N_IN;
  localparam int CFG_W   = ROWS;
  localparam int ROW_W   = N_IN;
  localparam int N_CHUNK = 4;
  localparam int CHUNK_W = CFG_W / N_CHUNK;

  typedef enum logic [1:0] {
    KIND_LUT6  = 2'b00,
    KIND_LUT5  = 2'b01,
    KIND_SHIFT = 2'b10,
    KIND_ALT6  = 2'b11
  } lut_kind_e;
endpackage

// File: rtl/lcg_edge.sv
module lcg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level && !level_q;

  // two rising edges can never be seen on back-to-back clocks
  assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lcg_minterm.sv
module lcg_minterm
  import lcg_pkg::*;
#(
  parameter logic [N_IN-1:0][CFG_W-1:0] BASIS = '0
) (
  input  logic [ROW_W-1:0] row,
  input  lut_kind_e        kind,
  input  logic [CFG_W-1:0] init,
  output logic             hit,
  output logic [CFG_W-1:0] term
);
  logic [N_IN-1:0][CFG_W-1:0] lit;

  for (genvar k = 0; k < N_IN; k++) begin : g_lit
    if (k == N_IN - 1) begin : g_top
      // the top input drops out of the product for 5-input logic
      assign lit[k] = (kind == KIND_LUT5) ? {CFG_W{1'b1}}
                    : (row[k] ? BASIS[k] : ~BASIS[k]);
    end else begin : g_low
      assign lit[k] = row[k] ? BASIS[k] : ~BASIS[k];
    end
  end

  always_comb begin
    term = {CFG_W{1'b1}};
    for (int k = 0; k < N_IN; k++) term &= lit[k];
  end

  always_comb begin
    case (kind)
      KIND_LUT5:  hit = !row[ROW_W-1] && init[row];
      KIND_SHIFT: hit = init[{1'b0, row[ROW_W-1:1]}];
      default:    hit = init[row];
    endcase
  end
endmodule

// File: rtl/lcg_reorder.sv
module lcg_reorder
  import lcg_pkg::*;
(
  input  logic             mem,
  input  logic [CFG_W-1:0] din,
  output logic [CFG_W-1:0] dout
);
  logic [N_CHUNK-1:0][CHUNK_W-1:0] ch;
  logic [N_CHUNK-1:0][CHUNK_W-1:0] sw;

  // ch[0] is the most significant chunk
  for (genvar i = 0; i < N_CHUNK; i++) begin : g_split
    assign ch[i] = din[CFG_W-1-i*CHUNK_W -: CHUNK_W];
  end

  assign sw[0] = ch[2];
  assign sw[1] = ch[3];
  assign sw[2] = ch[1];
  assign sw[3] = ch[0];

  always_comb begin
    dout = din;
    if (mem) begin
      for (int i = 0; i < N_CHUNK; i++)
        dout[CFG_W-1-i*CHUNK_W -: CHUNK_W] = sw[i];
    end
  end
endmodule

// File: rtl/lut_cfg_gen.sv
module lut_cfg_gen
  import lcg_pkg::*;
#(
  parameter logic [CFG_W-1:0] BASIS_A1 = 64'h5555555555555555,
  parameter logic [CFG_W-1:0] BASIS_A2 = 64'h3333333333333333,
  parameter logic [CFG_W-1:0] BASIS_A3 = 64'h0000FFFF0000FFFF,
  parameter logic [CFG_W-1:0] BASIS_A4 = 64'h0F0F0F0F0F0F0F0F,
  parameter logic [CFG_W-1:0] BASIS_A5 = 64'h00FF00FF00FF00FF,
  parameter logic [CFG_W-1:0] BASIS_A6 = 64'hFFFFFFFF00000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             start,
  input  logic [CFG_W-1:0] init_value,
  input  logic [1:0]       lut_kind,
  input  logic             mem_slice,
  output logic [CFG_W-1:0] cfg_string,
  output logic             cfg_ready
);
  localparam logic [N_IN-1:0][CFG_W-1:0] BASIS =
    {BASIS_A6, BASIS_A5, BASIS_A4, BASIS_A3, BASIS_A2, BASIS_A1};
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             rise;
  logic             busy;
  logic             ready_q;
  logic [ROW_W-1:0] row_cnt;
  logic [CFG_W-1:0] acc;
  logic [CFG_W-1:0] init_q;
  lut_kind_e        kind_q;
  logic             mem_q;
  logic             hit;
  logic [CFG_W-1:0] term;
  logic [CFG_W-1:0] shaped;

  lcg_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (start),
    .rise  (rise)
  );

  lcg_minterm #(.BASIS(BASIS)) u_term (
    .row  (row_cnt),
    .kind (kind_q),
    .init (init_q),
    .hit  (hit),
    .term (term)
  );

  lcg_reorder u_reorder (
    .mem  (mem_q),
    .din  (acc),
    .dout (shaped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ready_q <= 1'b0;
      row_cnt <= '0;
      acc     <= '0;
      init_q  <= '0;
      kind_q  <= KIND_LUT6;
      mem_q   <= 1'b0;
    end else if (soft_clr) begin
      busy    <= 1'b0;
      ready_q <= 1'b0;
      row_cnt <= '0;
      acc     <= '0;
    end else if (rise && !busy) begin
      busy    <= 1'b1;
      ready_q <= 1'b0;
      row_cnt <= '0;
      acc     <= '0;
      init_q  <= init_value;
      kind_q  <= lut_kind_e'(lut_kind);
      mem_q   <= mem_slice;
    end else if (busy) begin
      if (hit) acc <= acc | term;
      row_cnt <= row_cnt + 1'b1;
      if (row_cnt == LAST_ROW) begin
        busy    <= 1'b0;
        ready_q <= 1'b1;
      end
    end
  end

  assign cfg_ready  = ready_q;
  assign cfg_string = ready_q ? shaped : '0;

  // ready only appears straight after the final row was scanned
  assert_ready_after_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ready) |-> $past(row_cnt) == LAST_ROW);

  assert_start_launches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !busy && !soft_clr) |=> (busy && !cfg_ready));

  assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && !rise && !soft_clr) |=> (cfg_ready && $stable(cfg_string)));

  assert_busy_keeps_operands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && row_cnt != LAST_ROW && !soft_clr) |=> (busy && $stable(init_q)));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!cfg_ready && !busy && cfg_string == '0));
endmodule

// File: tb/lut_cfg_gen_test.sv
module lut_cfg_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic        start = 1'b0;
  logic [63:0] init_value = '0;
  logic [1:0]  lut_kind = 2'b00;
  logic        mem_slice = 1'b0;
  logic [63:0] cfg_string;
  logic        cfg_ready;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  lut_cfg_gen uut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .start(start),
    .init_value(init_value), .lut_kind(lut_kind), .mem_slice(mem_slice),
    .cfg_string(cfg_string), .cfg_ready(cfg_ready)
  );

  logic [63:0] b [6];
  initial begin
    b[0] = 64'h5555555555555555; b[1] = 64'h3333333333333333;
    b[2] = 64'h0000FFFF0000FFFF; b[3] = 64'h0F0F0F0F0F0F0F0F;
    b[4] = 64'h00FF00FF00FF00FF; b[5] = 64'hFFFFFFFF00000000;
  end

  function automatic logic [63:0] model_conv(logic [63:0] iv, logic [1:0] kd, logic m);
    logic [63:0] acc = '0;
    logic [63:0] t;
    logic [63:0] o;
    for (int r = 0; r < 64; r++) begin
      bit en;
      if (kd == 2'b01)      en = (r < 32) && iv[r];
      else if (kd == 2'b10) en = iv[r/2];
      else                  en = iv[r];
      if (en) begin
        t = '1;
        for (int k = 0; k < 6; k++) begin
          if (kd == 2'b01 && k == 5) continue;
          t &= ((r >> k) & 1) ? b[k] : ~b[k];
        end
        acc |= t;
      end
    end
    if (!m) return acc;
    o = {acc[31:16], acc[15:0], acc[47:32], acc[63:48]};
    return o;
  endfunction

  // cycle-level reference model
  bit m_busy, m_ready, m_sq;
  int m_cnt;
  logic [63:0] m_pend, m_res;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; m_sq = 0; m_cnt = 0; m_res = '0;
    end else begin
      bit rise;
      rise = start && !m_sq;
      m_sq = start;
      if (soft_clr) begin
        m_busy = 0; m_ready = 0; m_res = '0;
      end else if (rise && !m_busy) begin
        m_busy = 1; m_ready = 0; m_cnt = 0;
        m_pend = model_conv(init_value, lut_kind, mem_slice);
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == 64) begin m_busy = 0; m_ready = 1; m_res = m_pend; end
      end
    end
  end

  always @(negedge clk) begin
    logic [63:0] exp_s;
    exp_s = m_ready ? m_res : 64'h0;
    checks++;
    if (cfg_ready !== m_ready || cfg_string !== exp_s) begin
      fails++;
      $display("FAIL %s: ready=%0b string=%h expected ready=%0b string=%h",
               cur_req, cfg_ready, cfg_string, m_ready, exp_s);
    end
  end

  task automatic check_const(string req, logic [63:0] exp_v);
    checks++;
    if (cfg_ready !== 1'b1 || cfg_string !== exp_v) begin
      fails++;
      $display("FAIL %s: ready=%0b string=%h expected ready=1 string=%h",
               req, cfg_ready, cfg_string, exp_v);
    end
  endtask

  task automatic convert(logic [63:0] iv, logic [1:0] kd, logic m);
    init_value = iv; lut_kind = kd; mem_slice = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (66) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R10";
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R4";
    convert(64'h1, 2'b00, 1'b0);
    check_const("R4", 64'h0000000080000000);
    cur_req = "R7";
    convert(64'h1, 2'b00, 1'b1);
    check_const("R7", 64'h8000000000000000);
    cur_req = "R6";
    convert(64'h5, 2'b10, 1'b1);
    check_const("R6", 64'hC000C00000000000);
    convert(64'hFFFF_FFFF_0000_0005, 2'b10, 1'b1);
    check_const("R6", 64'hC000C00000000000);
    cur_req = "R5";
    convert(64'hFFFFFFFF00000000, 2'b01, 1'b0);
    check_const("R5", 64'h0);
    convert(64'h1234_5678_9ABC_DEF0, 2'b01, 1'b1);
    cur_req = "R4";
    convert(64'hDEAD_BEEF_0BAD_F00D, 2'b00, 1'b0);
    convert(64'hA5A5_0F0F_3C3C_9696, 2'b11, 1'b1);
    convert(64'hFFFFFFFFFFFFFFFF, 2'b00, 1'b0);
    check_const("R4", 64'hFFFFFFFFFFFFFFFF);

    // R1: level held high does not retrigger; R3: result held
    cur_req = "R1";
    init_value = 64'h0F1E_2D3C_4B5A_6978; lut_kind = 2'b00; mem_slice = 1'b1;
    start = 1'b1;
    repeat (140) @(negedge clk);
    start = 1'b0;
    cur_req = "R3";
    repeat (5) @(negedge clk);

    // R8: start pulses during scan and on the final row are ignored
    cur_req = "R8";
    init_value = 64'h0000_0000_0000_00C3; lut_kind = 2'b10; mem_slice = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    init_value = 64'hFFFF_0000_FFFF_0000; lut_kind = 2'b00;
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (52) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (70) @(negedge clk);

    // R9: clear mid-scan, and clear together with a start edge
    cur_req = "R9";
    init_value = 64'h1111_2222_3333_4444;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    soft_clr = 1'b1; @(negedge clk); soft_clr = 1'b0;
    repeat (70) @(negedge clk);
    convert(64'h7777_0000_1111_0000, 2'b00, 1'b0);
    soft_clr = 1'b1; start = 1'b1; @(negedge clk);
    soft_clr = 1'b0; start = 1'b0;
    repeat (70) @(negedge clk);

    // R10: asynchronous reset clears a finished result
    cur_req = "R10";
    convert(64'h0000_0000_0000_0F0F, 2'b01, 1'b0);
    #2 rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule